// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing half of a 128 KiB byte-addressed nonvolatile memory on a two-wire serial bus. A fast system clock oversamples the SCL and SDA lines and detects the start and stop conditions. The block decodes the device selection byte and acknowledges each byte it accepts. It collects a 17-bit memory address. The top address bit comes from the selection byte and the other sixteen come from two address bytes. Incoming write data is gathered in a one-page buffer and reaches the memory only when a clean stop ends the transfer. After that stop, a self-timed programming interval begins.

Reads start at the current address pointer, or at a pointer loaded by an address-only write, and continue byte after byte for as long as the bus master acknowledges. A write-protect input discards buffered data at the stop. The memory array sits outside the block behind a simple synchronous port with one cycle of read latency. The SDA line is open-drain: the block can only pull it low or release it.

Top module: `eeprom_twi_slave`

## Requirements
- R1: The selection byte is sent MSB first as code 1010, then strap_a[1], strap_a[0], then address bit 16, then the direction bit in the LSB (1 = read). If the code or either strap bit does not match, the byte gets no acknowledge and every later byte is ignored until the next start.
- R2: Each accepted byte is acknowledged by pulling SDA low for the ninth SCL clock. Incoming bits are sampled when SCL rises. The block changes SDA only while SCL is low.
- R3: A write sends the selection byte with direction 0, then address bits 15:8, then bits 7:0, then data bytes. Data bytes land at consecutive addresses once a stop arrives on a byte boundary.
- R4: In a write, the address increments only in its low 8 bits and wraps inside the 256-byte page. Past 256 bytes, later data replaces earlier data at the same offset, and only the last value is written.
- R5: After a committed write, the block acknowledges nothing and ignores the bus for WR_CYCLES clocks (never fewer than 256). After that, a selection byte is acknowledged again, so a master can poll for completion.
- R6: While wp_i is high at the stop, every byte is still acknowledged, but memory stays unchanged and no busy interval starts.
- R7: A start or stop that arrives after two or more SCL rises of a byte, or during its acknowledge clock, aborts the transfer. A write aborted this way writes nothing.
- R8: An address-only write followed by a repeated start and a read selection byte returns the byte at the loaded address.
- R9: A read with no preceding address returns the byte after the last one written or read. The address bit inside a read selection byte does not move the pointer.
- R10: A read continues to the next byte while the master acknowledges, and wraps from address 0x1FFFF to 0x00000. A master NACK ends the read and SDA is released.
- R11: After reset, SDA is released and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a | input | 2 | Board strap bits compared with the selection byte |
| wp_i | input | 1 | Write protect; high blocks every write |
| mem_addr | output | 17 | Memory array address |
| mem_we | output | 1 | Memory array write strobe |
| mem_wdata | output | 8 | Memory array write data |
| mem_rdata | input | 8 | Memory array read data, one cycle after mem_addr |

## Verification
A start condition and the self-timed programming interval can coincide: a master that polls right after its stop sends a start while the interval is still running. The bench provokes this by polling right after every committed write. It expects the first poll to go unacknowledged and a later poll to be acknowledged. On every clock, the bench also compares each memory write strobe against the set of writes its reference model expects. This shows that neither a poll nor the page sweep writes anything it should not.

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave #(
  parameter int         PAGE_W    = 8,
  parameter int         WR_CYCLES = 1250000,
  parameter logic [3:0] DEV_CODE  = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull,
  input  logic [1:0]  strap_a,
  input  logic        wp_i,
  output logic [16:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BUSY       = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
  localparam int CW         = $clog2(BUSY + 1);
  localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY - 1);
  localparam logic [CW-1:0] PAGE_LIM  = CW'(PAGE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_TX} ph_t;

  logic [2:0] scl_q, sda_q;
  logic scl, scl_d, sda, sda_d;
  logic rise, fall, start_c, stop_c;

  ph_t                 ph;
  logic [3:0]          bitcnt;
  logic [7:0]          shr;
  logic [1:0]          idx;
  logic                rw, mack, have_data, wcyc, p0_hold;
  logic [7:0]          hi_hold;
  logic [CW-1:0]       wcnt;
  logic [16:0]         ptr;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval;
  logic                take_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  assign scl     = scl_q[1];
  assign scl_d   = scl_q[2];
  assign sda     = sda_q[1];
  assign sda_d   = sda_q[2];
  assign rise    = scl & ~scl_d;
  assign fall    = ~scl & scl_d;
  assign start_c = scl & scl_d & sda_d & ~sda;
  assign stop_c  = scl & scl_d & ~sda_d & sda;

  assign take_data = !wcyc && !start_c && !stop_c && ph == S_RX && fall &&
                     bitcnt == 4'd8 && idx == 2'd3;

  assign mem_we    = wcyc && (wcnt < PAGE_LIM) && pval[wcnt[PAGE_W-1:0]];
  assign mem_addr  = wcyc ? {ptr[16:PAGE_W], wcnt[PAGE_W-1:0]} : ptr;
  assign mem_wdata = pbuf[wcnt[PAGE_W-1:0]];

  always_ff @(posedge clk)
    if (take_data) pbuf[ptr[PAGE_W-1:0]] <= shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= S_IDLE;
      bitcnt    <= '0;
      shr       <= '0;
      idx       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      have_data <= 1'b0;
      wcyc      <= 1'b0;
      wcnt      <= '0;
      ptr       <= '0;
      pval      <= '0;
      hi_hold   <= '0;
      p0_hold   <= 1'b0;
      sda_pull  <= 1'b0;
    end else if (wcyc) begin
      ph       <= S_IDLE;
      sda_pull <= 1'b0;
      if (wcnt == BUSY_LAST) begin
        wcyc <= 1'b0;
        wcnt <= '0;
        pval <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (start_c) begin
      ph        <= S_RX;
      bitcnt    <= '0;
      idx       <= '0;
      sda_pull  <= 1'b0;
      pval      <= '0;
      have_data <= 1'b0;
    end else if (stop_c) begin
      ph       <= S_IDLE;
      sda_pull <= 1'b0;
      if (ph == S_RX && !rw && have_data && bitcnt <= 4'd1 && !wp_i) begin
        wcyc <= 1'b1;
        wcnt <= '0;
      end
    end else if (ph != S_IDLE) begin
      if (rise) begin
        if (bitcnt < 4'd8 && ph == S_RX) shr <= {shr[6:0], sda};
        if (bitcnt == 4'd8) mack <= ~sda;
        if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (fall) begin
        if (ph == S_RX) begin
          if (bitcnt == 4'd8) begin
            if (idx == 2'd0) begin
              if (shr[7:4] == DEV_CODE && shr[3:2] == strap_a) begin
                sda_pull <= 1'b1;
                rw       <= shr[0];
                p0_hold  <= shr[1];
              end else begin
                ph <= S_IDLE;
              end
            end else begin
              sda_pull <= 1'b1;
              if (idx == 2'd1) hi_hold <= shr;
              else if (idx == 2'd2) ptr <= {p0_hold, hi_hold, shr};
              else begin
                pval[ptr[PAGE_W-1:0]] <= 1'b1;
                have_data <= 1'b1;
                ptr <= {ptr[16:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              end
            end
          end else if (bitcnt == 4'd9) begin
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            if (idx != 2'd3) idx <= idx + 2'd1;
            if (idx == 2'd0 && rw) begin
              ph       <= S_TX;
              shr      <= mem_rdata;
              sda_pull <= ~mem_rdata[7];
              ptr      <= ptr + 1'b1;
            end
          end
        end else begin
          if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
            shr      <= {shr[6:0], 1'b0};
            sda_pull <= ~shr[6];
          end else if (bitcnt == 4'd8) begin
            sda_pull <= 1'b0;
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (mack) begin
              shr      <= mem_rdata;
              sda_pull <= ~mem_rdata[7];
              ptr      <= ptr + 1'b1;
            end else begin
              ph <= S_IDLE;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_twi_slave_chk.sv
module eeprom_twi_slave_chk #(
  parameter int PAGE_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_pull,
  input logic        wp_i,
  input logic        mem_we,
  input logic [16:0] mem_addr,
  input logic        wcyc
);
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wcyc |-> !sda_pull);

  p_same_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      (mem_addr[16:PAGE_W] == $past(mem_addr[16:PAGE_W]) &&
       mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0])));

  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcyc) |-> !$past(wp_i));
endmodule

bind eeprom_twi_slave eeprom_twi_slave_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_pull (sda_pull),
  .wp_i     (wp_i),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .wcyc     (wcyc)
);

// File: tb/eeprom_twi_slave_bench.sv
module eeprom_twi_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_line, sda_pull, mem_we;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata, rdata;
  logic [7:0] ram [int];
  logic [7:0] refm [int];
  logic [7:0] exp_wr [int];
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  eeprom_twi_slave #(.PAGE_W(8), .WR_CYCLES(600)) u_eeprom_twi_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .strap_a(strap), .wp_i(wp), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(rdata));

  function automatic logic [7:0] seed(int a);
    logic [16:0] x;
    x = a[16:0];
    return x[7:0] ^ x[15:8] ^ {x[16], 7'b0} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] peek(int a);
    return ram.exists(a) ? ram[a] : seed(a);
  endfunction
  function automatic logic [7:0] ref_val(int a);
    return refm.exists(a) ? refm[a] : seed(a);
  endfunction
  function automatic logic [7:0] dev(logic p, logic r);
    return {4'b1010, 2'b10, p, r};
  endfunction

  always @(posedge clk) begin
    int a;
    a = int'(mem_addr);
    rdata <= peek(a);
    if (mem_we) ram[a] = mem_wdata;
  end

  always @(negedge clk) if (rst_n && mem_we) begin
    int a;
    a = int'(mem_addr);
    compared++;
    if (!exp_wr.exists(a) || exp_wr[a] !== mem_wdata) begin
      mismatched++;
      $display("FAIL R3/R6/R7 write at %h: got %h expected %s", a, mem_wdata,
               exp_wr.exists(a) ? $sformatf("%h", exp_wr[a]) : "no write");
    end else exp_wr.delete(a);
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  task automatic wq(); repeat (6) @(negedge clk); endtask
  task automatic m_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic m_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic m_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1; wq(); s = sda_line; wq(); scl_m = 0; wq();
  endtask
  task automatic m_wr(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(d[i], s);
    m_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic m_rd(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, s); d[i] = s; end
    m_bit(~give_ack, s);
  endtask

  task automatic addr_phase(int a);
    logic k;
    m_start();
    m_wr(dev(a[16], 1'b0), k); check("R2 select ack", k, 1);
    m_wr(a[15:8], k);          check("R2 high address ack", k, 1);
    m_wr(a[7:0], k);           check("R2 low address ack", k, 1);
  endtask

  task automatic wait_ready(output int polls);
    logic k;
    polls = 0;
    for (int n = 0; n < 20; n++) begin
      m_start(); m_wr(dev(1'b0, 1'b0), k); m_stop();
      if (k) break;
      polls++;
    end
  endtask

  task automatic page_write(int a, input logic [7:0] q[$], input string req);
    logic k;
    int off;
    addr_phase(a);
    off = a & 255;
    foreach (q[i]) begin
      m_wr(q[i], k); check(req, k, 1);
      if (!wp) begin
        exp_wr[(a & 32'h1FF00) | off] = q[i];
        refm[(a & 32'h1FF00) | off] = q[i];
      end
      off = (off + 1) & 255;
    end
    m_stop();
  endtask

  task automatic rand_read(int a, int n, string req);
    logic k;
    logic [7:0] d;
    addr_phase(a);
    m_start();
    m_wr(dev(1'b0, 1'b1), k); check("R8 read select ack", k, 1);
    for (int i = 0; i < n; i++) begin
      m_rd(i < n - 1, d);
      check(req, d, ref_val((a + i) & 32'h1FFFF));
    end
    m_stop();
  endtask

  initial begin
    int polls;
    logic k, s;
    logic [7:0] d;
    logic [7:0] q[$];
    repeat (10) @(negedge clk);
    check("R11 reset sda", sda_pull, 0);
    check("R11 reset we", mem_we, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R11 idle sda", sda_pull, 0);

    m_start(); m_wr(8'hA4, k); check("R1 strap mismatch nack", k, 0);
    m_wr(dev(1'b0, 1'b0), k); check("R1 ignored after mismatch", k, 0);
    m_stop();
    m_start(); m_wr(8'hB8, k); check("R1 code mismatch nack", k, 0); m_stop();

    q = '{8'hA5};
    page_write(32'h12345, q, "R3 data ack");
    wait_ready(polls);
    check("R5 busy after commit", polls > 0, 1);
    check("R5 ready again", polls < 20, 1);
    check("R3 all writes seen", exp_wr.size(), 0);
    rand_read(32'h12345, 1, "R8 random read");
    m_start(); m_wr(dev(1'b0, 1'b1), k); check("R9 current read ack", k, 1);
    m_rd(1'b0, d); check("R9 current address", d, ref_val(32'h12346)); m_stop();
    rand_read(32'h02345, 1, "R3 address bit 16 selects");

    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    page_write(32'h001FE, q, "R4 data ack");
    wait_ready(polls);
    check("R4 all writes seen", exp_wr.size(), 0);
    rand_read(32'h001FE, 2, "R4 page end");
    rand_read(32'h00100, 2, "R4 wrapped start");

    q = {};
    for (int i = 0; i < 258; i++) q.push_back(i >= 256 ? 8'hE0 + 8'(i - 256) : 8'(i * 3));
    page_write(32'h10300, q, "R4 long data ack");
    wait_ready(polls);
    check("R4 overwrite writes seen", exp_wr.size(), 0);
    rand_read(32'h10300, 3, "R4 overwritten bytes");

    wp = 1;
    q = '{8'h77};
    page_write(32'h00010, q, "R6 ack under protect");
    wait_ready(polls);
    check("R6 no busy interval", polls, 0);
    wp = 0;
    rand_read(32'h00010, 1, "R6 memory unchanged");

    addr_phase(32'h00020);
    m_wr(8'h99, k); check("R7 data ack", k, 1);
    for (int i = 0; i < 3; i++) m_bit(1'b0, s);
    m_stop();
    wait_ready(polls);
    check("R7 stop abort no busy", polls, 0);
    rand_read(32'h00020, 1, "R7 stop abort memory");

    addr_phase(32'h00030);
    m_wr(8'h55, k); check("R7 data ack", k, 1);
    for (int i = 0; i < 4; i++) m_bit(1'b1, s);
    m_start(); m_wr(dev(1'b0, 1'b1), k); check("R7 restart select ack", k, 1);
    m_rd(1'b0, d); check("R7 R9 pointer after abort", d, ref_val(32'h00031));
    m_stop();
    wait_ready(polls);
    check("R7 restart abort no busy", polls, 0);
    rand_read(32'h00030, 1, "R7 restart abort memory");

    rand_read(32'h1FFFE, 3, "R10 sequential wrap");
    check("R10 released after nack", sda_pull, 0);

    summary();
    $finish;
  end
endmodule